// File: doc/BRIEF.md
# SDRAM Bank State and Timing Checker

This block sits beside a memory controller and watches the already-decoded SDRAM command stream, one command per clock. It keeps a small state machine for each bank and a device-wide refresh timer. For each command it reports in the same cycle whether the command is legal. An illegal command gets a cause code and has no effect on any tracked state. The block also predicts, cycle by cycle, when read data should be on the data bus. A controller's own data-valid strobe can be compared against that prediction.

Each bank moves through four states. `BK_IDLE` goes to `BK_OPENING` on a legal activate. `BK_OPENING` goes to `BK_OPEN` once the row-to-column delay has elapsed, or to `BK_CLOSING` on a legal precharge. `BK_OPEN` goes to `BK_CLOSING` on a legal precharge or precharge-all. `BK_CLOSING` goes back to `BK_IDLE` once the precharge time has elapsed, or straight to `BK_OPENING` if an activate arrives on the first cycle that is allowed. Row and column addresses do not affect legality, so the block does not take them.

Top module: `sdram_cmd_checker`

## Requirements
- R1: After reset all banks are idle (`bank_open` = 0), `rd_valid` is 0, and a NOP reports `cmd_ok` = 1 with `viol_code` = 0.
- R2: Read (code 2), write (3) or precharge (4) aimed at a bank that is not open is rejected with `viol_code` 3.
- R3: A read or write sent fewer than TRCD cycles after the activate of its bank is rejected with code 5. One sent exactly TRCD cycles later is accepted.
- R4: A precharge of a bank sent fewer than TRAS cycles after its activate is rejected with code 6. Precharge-all (5) is rejected with code 6 if any open bank has not met TRAS.
- R5: An activate (1) to a bank fewer than TRP cycles after its precharge is rejected with code 7. One sent exactly TRP cycles later is accepted.
- R6: Auto refresh (7) and load mode (8) are rejected with code 8 unless every bank is idle. For TRFC cycles after an accepted refresh, every command except NOP is rejected with code 2.
- R7: A read accepted on cycle N drives `rd_valid` high on cycles N+CL through N+CL+BL-1.
- R8: An accepted read, burst stop (6), precharge-all, or precharge to the bank of the last read, issued on cycle M, ends an earlier burst from cycle M+CL onward. A precharge to any other bank does not shorten the burst.
- R9: NOP (0) is always accepted. Commands to other banks are accepted while one bank waits out TRCD. Burst stop and write to an open, ready bank are accepted.
- R10: A rejected command leaves `bank_open` and the read prediction unchanged.
- R11: An accepted precharge-all moves every open bank to closing. Each such bank then needs its own TRP before it can be activated again.
- R12: An activate to an open bank is rejected with code 4. Any code above 8 is rejected with code 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_code | input | 4 | Decoded command of this cycle (0 NOP … 8 load mode) |
| cmd_bank | input | BW | Bank addressed by the command |
| cmd_ok | output | 1 | Command of this cycle is legal |
| viol_code | output | 4 | Cause of rejection, 0 when legal |
| rd_valid | output | 1 | Predicted read data on the bus this cycle |
| bank_open | output | NB | Per-bank flag: bank is opening or open |

## Verification
The hardest situation to reach is a command that shortens a read burst. The command has to arrive while the earlier read is still inside its CAS-latency delay or only partly out. It must also be legal, because an illegal one must not cut anything. The stimulus opens two banks and lets their TRAS expire. It then issues a read followed one or two cycles later by a burst stop, a second read, a precharge of the other bank, or a precharge-all. The expected data window is rebuilt each cycle from the issue cycles, so a window that is one cycle early or late shows up as a mismatch.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_ACT  = 4'd1,
        CMD_RD   = 4'd2,
        CMD_WR   = 4'd3,
        CMD_PRE  = 4'd4,
        CMD_PREA = 4'd5,
        CMD_BST  = 4'd6,
        CMD_REF  = 4'd7,
        CMD_LMR  = 4'd8
    } cmd_e;

    typedef enum logic [3:0] {
        VC_NONE      = 4'd0,
        VC_BAD_OP    = 4'd1,
        VC_REF_BUSY  = 4'd2,
        VC_NOT_OPEN  = 4'd3,
        VC_BANK_OPEN = 4'd4,
        VC_TRCD      = 4'd5,
        VC_TRAS      = 4'd6,
        VC_TRP       = 4'd7,
        VC_NOT_IDLE  = 4'd8
    } viol_e;

    typedef enum logic [1:0] {
        BK_IDLE,
        BK_OPENING,
        BK_OPEN,
        BK_CLOSING
    } bank_st_e;

endpackage

// File: rtl/bank_timer_fsm.sv
module bank_timer_fsm
    import sdram_chk_pkg::*;
#(
    parameter int TRCD = 3,
    parameter int TRAS = 6,
    parameter int TRP  = 3,
    parameter int CW   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_go,
    input  logic pre_go,
    input  logic rw_go,
    output logic is_open,
    output logic rcd_ok,
    output logic ras_ok,
    output logic rp_ok
);

    localparam logic [CW-1:0] RCD_LOAD = CW'(TRCD - 1);
    localparam logic [CW-1:0] RAS_LOAD = CW'(TRAS - 1);
    localparam logic [CW-1:0] RP_LOAD  = CW'(TRP - 1);

    bank_st_e        st, st_nx;
    logic [CW-1:0]   tmr, tmr_nx;
    logic [CW-1:0]   ras_tmr, ras_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= BK_IDLE;
            tmr     <= '0;
            ras_tmr <= '0;
        end else begin
            st      <= st_nx;
            tmr     <= tmr_nx;
            ras_tmr <= ras_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        tmr_nx = (tmr != '0) ? tmr - 1'b1 : '0;
        ras_nx = (ras_tmr != '0) ? ras_tmr - 1'b1 : '0;
        unique case (st)
            BK_IDLE: begin
                if (act_go) begin
                    st_nx  = BK_OPENING;
                    tmr_nx = RCD_LOAD;
                    ras_nx = RAS_LOAD;
                end
            end
            BK_OPENING: begin
                if (pre_go) begin
                    st_nx  = BK_CLOSING;
                    tmr_nx = RP_LOAD;
                end else if (tmr == '0) begin
                    st_nx = BK_OPEN;
                end
            end
            BK_OPEN: begin
                if (pre_go) begin
                    st_nx  = BK_CLOSING;
                    tmr_nx = RP_LOAD;
                end
            end
            BK_CLOSING: begin
                if (act_go) begin
                    st_nx  = BK_OPENING;
                    tmr_nx = RCD_LOAD;
                    ras_nx = RAS_LOAD;
                end else if (tmr == '0) begin
                    st_nx = BK_IDLE;
                end
            end
            default: st_nx = BK_IDLE;
        endcase
    end

    always_comb begin
        is_open = (st == BK_OPENING) || (st == BK_OPEN);
        rcd_ok  = (st == BK_OPEN) || ((st == BK_OPENING) && (tmr == '0));
        ras_ok  = (ras_tmr == '0);
        rp_ok   = (st == BK_IDLE) || ((st == BK_CLOSING) && (tmr == '0));
    end

    AST_RW_AFTER_RCD: assert property (@(posedge clk) disable iff (!rst_n)
        rw_go |-> rcd_ok);  // R3
    AST_PRE_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        pre_go |-> (ras_ok && is_open));  // R4
    AST_ACT_AFTER_RP: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |-> rp_ok);  // R5
    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |=> (is_open && !rcd_ok || TRCD == 1));  // R12

endmodule

// File: rtl/cmd_legality.sv
module cmd_legality
    import sdram_chk_pkg::*;
#(
    parameter int NB = 4,
    parameter int BW = 2
) (
    input  logic [3:0]    cmd_code,
    input  logic [BW-1:0] cmd_bank,
    input  logic [NB-1:0] is_open,
    input  logic [NB-1:0] rcd_ok,
    input  logic [NB-1:0] ras_ok,
    input  logic [NB-1:0] rp_ok,
    input  logic          ref_busy,
    input  logic [BW-1:0] last_rd_bank,
    output logic          ok,
    output viol_e         code,
    output logic [NB-1:0] act_go,
    output logic [NB-1:0] pre_go,
    output logic [NB-1:0] rw_go,
    output logic          rd_start,
    output logic          rd_cut
);

    cmd_e op;

    always_comb begin
        op   = cmd_e'(cmd_code);
        code = VC_NONE;
        unique case (op)
            CMD_NOP: code = VC_NONE;
            CMD_ACT: begin
                if (ref_busy)                code = VC_REF_BUSY;
                else if (is_open[cmd_bank])  code = VC_BANK_OPEN;
                else if (!rp_ok[cmd_bank])   code = VC_TRP;
            end
            CMD_RD, CMD_WR: begin
                if (ref_busy)                code = VC_REF_BUSY;
                else if (!is_open[cmd_bank]) code = VC_NOT_OPEN;
                else if (!rcd_ok[cmd_bank])  code = VC_TRCD;
            end
            CMD_PRE: begin
                if (ref_busy)                code = VC_REF_BUSY;
                else if (!is_open[cmd_bank]) code = VC_NOT_OPEN;
                else if (!ras_ok[cmd_bank])  code = VC_TRAS;
            end
            CMD_PREA: begin
                if (ref_busy)                      code = VC_REF_BUSY;
                else if (!(&(ras_ok | ~is_open)))  code = VC_TRAS;
            end
            CMD_BST: begin
                if (ref_busy) code = VC_REF_BUSY;
            end
            CMD_REF, CMD_LMR: begin
                if (ref_busy)       code = VC_REF_BUSY;
                else if (!(&rp_ok)) code = VC_NOT_IDLE;
            end
            default: code = VC_BAD_OP;
        endcase
        ok = (code == VC_NONE);
    end

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            act_go[i] = ok && (op == CMD_ACT) && (cmd_bank == BW'(i));
            rw_go[i]  = ok && ((op == CMD_RD) || (op == CMD_WR)) && (cmd_bank == BW'(i));
            pre_go[i] = ok && (((op == CMD_PRE) && (cmd_bank == BW'(i))) ||
                               ((op == CMD_PREA) && is_open[i]));
        end
        rd_start = ok && (op == CMD_RD);
        rd_cut   = ok && ((op == CMD_BST) || (op == CMD_PREA) ||
                          ((op == CMD_PRE) && (cmd_bank == last_rd_bank)));
    end

endmodule

// File: rtl/rd_window.sv
module rd_window #(
    parameter int CL = 3,
    parameter int BL = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_start,
    input  logic rd_cut,
    output logic rd_valid
);

    localparam int RW = $clog2(BL + 1);
    localparam logic [RW-1:0] REM_LOAD = RW'(BL - 1);

    logic [CL-1:0] pipe_rd;
    logic [CL-1:0] pipe_cut;
    logic [RW-1:0] rem, rem_nx;
    logic          head_rd, head_cut;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_rd  <= '0;
            pipe_cut <= '0;
            rem      <= '0;
        end else begin
            pipe_rd[0]  <= rd_start;
            pipe_cut[0] <= rd_cut;
            for (int k = 1; k < CL; k++) begin
                pipe_rd[k]  <= pipe_rd[k-1];
                pipe_cut[k] <= pipe_cut[k-1];
            end
            rem <= rem_nx;
        end
    end

    always_comb begin
        head_rd  = pipe_rd[CL-1];
        head_cut = pipe_cut[CL-1];
        rd_valid = head_rd || (!head_cut && (rem != '0));
        if (head_rd)           rem_nx = REM_LOAD;
        else if (head_cut)     rem_nx = '0;
        else if (rem != '0)    rem_nx = rem - 1'b1;
        else                   rem_nx = '0;
    end

    AST_HEAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({head_rd, head_cut}));  // R8
    AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rem <= REM_LOAD);  // R7

endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
    import sdram_chk_pkg::*;
#(
    parameter int NB   = 4,
    parameter int TRCD = 3,
    parameter int TRAS = 6,
    parameter int TRP  = 3,
    parameter int TRFC = 8,
    parameter int CL   = 3,
    parameter int BL   = 4,
    localparam int BW  = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    cmd_code,
    input  logic [BW-1:0] cmd_bank,
    output logic          cmd_ok,
    output logic [3:0]    viol_code,
    output logic          rd_valid,
    output logic [NB-1:0] bank_open
);

    localparam int TMAX = (TRAS > TRCD) ? ((TRAS > TRP) ? TRAS : TRP)
                                        : ((TRCD > TRP) ? TRCD : TRP);
    localparam int CW = $clog2(TMAX + 1);
    localparam int FW = $clog2(TRFC + 1);
    localparam logic [FW-1:0] RFC_LOAD = FW'(TRFC - 1);

    logic [NB-1:0] act_go, pre_go, rw_go;
    logic [NB-1:0] rcd_ok, ras_ok, rp_ok;
    logic [FW-1:0] rfc_tmr;
    logic          ref_busy;
    logic [BW-1:0] last_rd_bank;
    logic          rd_start, rd_cut;
    viol_e         code_w;

    for (genvar g = 0; g < NB; g++) begin : g_bank
        bank_timer_fsm #(
            .TRCD(TRCD), .TRAS(TRAS), .TRP(TRP), .CW(CW)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .act_go  (act_go[g]),
            .pre_go  (pre_go[g]),
            .rw_go   (rw_go[g]),
            .is_open (bank_open[g]),
            .rcd_ok  (rcd_ok[g]),
            .ras_ok  (ras_ok[g]),
            .rp_ok   (rp_ok[g])
        );
    end

    cmd_legality #(.NB(NB), .BW(BW)) u_rules (
        .cmd_code     (cmd_code),
        .cmd_bank     (cmd_bank),
        .is_open      (bank_open),
        .rcd_ok       (rcd_ok),
        .ras_ok       (ras_ok),
        .rp_ok        (rp_ok),
        .ref_busy     (ref_busy),
        .last_rd_bank (last_rd_bank),
        .ok           (cmd_ok),
        .code         (code_w),
        .act_go       (act_go),
        .pre_go       (pre_go),
        .rw_go        (rw_go),
        .rd_start     (rd_start),
        .rd_cut       (rd_cut)
    );

    rd_window #(.CL(CL), .BL(BL)) u_rdwin (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_start (rd_start),
        .rd_cut   (rd_cut),
        .rd_valid (rd_valid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rfc_tmr      <= '0;
            last_rd_bank <= '0;
        end else begin
            if (cmd_ok && (cmd_code == CMD_REF)) rfc_tmr <= RFC_LOAD;
            else if (rfc_tmr != '0)              rfc_tmr <= rfc_tmr - 1'b1;
            if (rd_start) last_rd_bank <= cmd_bank;
        end
    end

    always_comb begin
        ref_busy  = (rfc_tmr != '0);
        viol_code = code_w;
    end

    AST_HOLD_ON_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ok |=> $stable(bank_open));  // R10
    AST_REF_ALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && (cmd_code == CMD_REF)) |-> (bank_open == '0));  // R6
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_busy && (cmd_code != CMD_NOP)) |-> !cmd_ok);  // R6
    AST_NOP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_NOP) |-> cmd_ok);  // R9

endmodule

// File: tb/sdram_cmd_checker_bench.sv
`timescale 1ns/1ps
module sdram_cmd_checker_bench;
    import sdram_chk_pkg::*;

    localparam int NB = 4, TRCD = 3, TRAS = 6, TRP = 3, TRFC = 8, CL = 3, BL = 4;

    typedef struct {
        int         cyc;
        logic [3:0] code;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cmd_code = 4'd0;
    logic [1:0] cmd_bank = 2'd0;
    logic       cmd_ok, rd_valid;
    logic [3:0] viol_code;
    logic [3:0] bank_open;

    int   cyc = 0;
    int   total = 0, bad = 0;
    bit   mon_en = 1'b0;
    bit   exp_rv [0:1023];
    int   last_rd = -1;
    exp_t q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_cmd_checker #(
        .NB(NB), .TRCD(TRCD), .TRAS(TRAS), .TRP(TRP), .TRFC(TRFC), .CL(CL), .BL(BL)
    ) u_sdram_cmd_checker (
        .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
        .cmd_ok(cmd_ok), .viol_code(viol_code), .rd_valid(rd_valid), .bank_open(bank_open)
    );

    task automatic check(input bit cond, input string req, input int act, input int expv);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, expv);
        end
    endtask

    task automatic issue(input logic [3:0] op, input int bk, input logic [3:0] code, input string req);
        exp_t e;
        @(posedge clk); #1;
        cmd_code = op;
        cmd_bank = bk[1:0];
        e.cyc = cyc; e.code = code; e.req = req;
        q.push_back(e);
        if (code == 4'd0) begin
            if (op == CMD_RD || op == CMD_BST || op == CMD_PREA || (op == CMD_PRE && bk == last_rd))
                for (int k = 0; k <= BL; k++) exp_rv[cyc + CL + k] = 1'b0;
            if (op == CMD_RD) begin
                for (int k = 0; k < BL; k++) exp_rv[cyc + CL + k] = 1'b1;
                last_rd = bk;
            end
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk); #1;
            cmd_code = CMD_NOP;
        end
    endtask

    task automatic chk_open(input logic [3:0] expv, input string req);
        @(negedge clk);
        check(bank_open == expv, req, bank_open, expv);
    endtask

    // monitor: pops the scoreboard and compares the predicted read window
    always @(negedge clk) begin
        if (mon_en) begin
            if (q.size() > 0 && q[0].cyc == cyc) begin
                exp_t e;
                e = q.pop_front();
                check(viol_code == e.code, e.req, viol_code, e.code);
                check(cmd_ok == (e.code == 4'd0), e.req, cmd_ok, (e.code == 4'd0));
            end
            check(rd_valid == exp_rv[cyc], "R7/R8 read window", rd_valid, exp_rv[cyc]);
        end
    end

    initial begin
        #(4 * 20000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(bank_open == 4'b0000, "R1 banks idle", bank_open, 0);
        check(rd_valid == 1'b0, "R1 no read data", rd_valid, 0);
        check(cmd_ok == 1'b1 && viol_code == 4'd0, "R1 NOP legal", viol_code, 0);
        mon_en = 1'b1;

        // accesses to closed banks
        issue(CMD_RD,  0, VC_NOT_OPEN, "R2 read idle bank");
        issue(CMD_WR,  1, VC_NOT_OPEN, "R2 write idle bank");
        issue(CMD_PRE, 2, VC_NOT_OPEN, "R2 precharge idle bank");
        issue(CMD_BST, 0, VC_NONE,     "R9 burst stop legal");
        idle(1);

        // activate, row-to-column delay, other bank in the wait
        issue(CMD_ACT, 0, VC_NONE,      "R9 activate bank0");
        issue(CMD_RD,  0, VC_TRCD,      "R3 early read");
        issue(CMD_ACT, 1, VC_NONE,      "R9 other bank during tRCD");
        issue(CMD_RD,  0, VC_NONE,      "R3 read at tRCD");
        issue(CMD_ACT, 0, VC_BANK_OPEN, "R12 activate open bank");
        issue(4'hF,    0, VC_BAD_OP,    "R12 undefined opcode");
        idle(1);
        chk_open(4'b0011, "R10 state after rejects");
        idle(6);

        // burst cut by burst stop
        issue(CMD_RD,  0, VC_NONE, "R8 read before stop");
        idle(1);
        issue(CMD_BST, 0, VC_NONE, "R8 burst stop");
        idle(8);
        // precharge of other bank does not cut
        issue(CMD_RD,  0, VC_NONE, "R8 read before foreign precharge");
        issue(CMD_PRE, 1, VC_NONE, "R8 precharge other bank");
        idle(8);
        // read cut by a later read
        issue(CMD_RD, 0, VC_NONE, "R7 first read");
        idle(1);
        issue(CMD_RD, 0, VC_NONE, "R8 second read");
        idle(9);
        issue(CMD_WR, 0, VC_NONE, "R9 write legal");
        idle(1);

        // tRAS and tRP on bank 2
        issue(CMD_ACT, 2, VC_NONE, "R4 activate bank2");
        idle(1);
        issue(CMD_PRE, 2, VC_TRAS, "R4 early precharge");
        idle(1);
        chk_open(4'b0101, "R10 state after tRAS reject");
        idle(2);
        issue(CMD_PRE, 2, VC_NONE, "R4 precharge at tRAS");
        issue(CMD_ACT, 2, VC_TRP,  "R5 early activate");
        idle(1);
        issue(CMD_ACT, 2, VC_NONE, "R5 activate at tRP");

        // all-bank commands
        issue(CMD_REF, 0, VC_NOT_IDLE, "R6 refresh with open banks");
        issue(CMD_LMR, 0, VC_NOT_IDLE, "R6 mode load with open banks");
        idle(6);
        issue(CMD_RD,   0, VC_NONE, "R8 read before precharge-all");
        issue(CMD_PREA, 0, VC_NONE, "R11 precharge-all");
        issue(CMD_ACT,  2, VC_TRP,  "R11 activate inside tRP");
        idle(1);
        chk_open(4'b0000, "R11 all closing");
        issue(CMD_REF, 0, VC_NONE,     "R6 refresh all idle");
        issue(CMD_ACT, 1, VC_REF_BUSY, "R6 activate during refresh");
        issue(CMD_NOP, 0, VC_NONE,     "R9 NOP during refresh");
        idle(4);
        issue(CMD_LMR, 0, VC_REF_BUSY, "R6 mode load during refresh");
        issue(CMD_LMR, 0, VC_NONE,     "R6 mode load after tRFC");
        issue(CMD_ACT, 1, VC_NONE,     "R6 activate after tRFC");
        idle(2);
        chk_open(4'b0010, "R6 bank1 open");
        idle(4);

        mon_en = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule